// File: doc/BRIEF.md
# Virtual Address Translation Front-End

This block sits between a requester (fetch or load/store path) and a page-table walker in a 64-bit memory system. For each request it takes a virtual address, an access kind and the effective privilege. Using a translation control word held by software, it picks one of three treatments: pass the address through untouched, start a three-level walk over a 39-bit address space, or start a four-level walk over a 48-bit address space.

Before any walk is started, the address must be canonical for the chosen scheme. If it is not, no walk is issued and a page-fault cause that matches the access kind is returned at once. A walk request carries the truncated address, the address-space identifier, the root page number, the starting level and the two permission-relaxation flags from the status word. The walker's physical address comes back zero-extended to 64 bits.

Only one request is in flight at a time, so responses leave in the order requests were accepted. Every port is a valid/ready pair, except the walker response, which is a valid-only return.

Top module: `xlate_front`

## Requirements
- R1: When `req_priv` is 2'b11 (machine), the response gives `rsp_paddr` equal to `req_vaddr` with `rsp_fault` low and no walk request, whatever `atp_ctrl` holds and whether or not the address is canonical.
- R2: The scheme is taken from `atp_ctrl[63:60]`: 8 selects the three-level 39-bit scheme, 9 selects the four-level 48-bit scheme, and 0 or any other value selects pass-through.
- R3: Under the 39-bit scheme, an address is canonical only when bits 63..39 all equal bit 38.
- R4: Under the 48-bit scheme, an address is canonical only when bits 63..48 all equal bit 47.
- R5: A non-canonical address issues no walk. It returns `rsp_fault` high with `rsp_cause` 12 for fetch (`req_acc`=0), 13 for load (1) and 15 for store (2) or atomic (3), and `rsp_paddr` zero.
- R6: A walk request carries `req_vaddr[38:0]` zero-extended to 48 bits with `wk_level`=2 for the 39-bit scheme, or `req_vaddr[47:0]` with `wk_level`=3 for the 48-bit scheme.
- R7: A walk request carries `wk_asid`=`atp_ctrl[59:44]`, `wk_root`=`atp_ctrl[43:0]`, and `wk_mxr`/`wk_sum` equal to `st_mxr`/`st_sum` at acceptance.
- R8: A successful walk response (`wr_fault` low) returns `wr_paddr` zero-extended to 64 bits with `rsp_fault` low and `rsp_cause` 0. A failed walk returns `rsp_fault` high, `rsp_paddr` zero and the cause from R5 for the access kind.
- R9: After reset, `req_ready` is high and `rsp_valid` and `wk_valid` are low. A pass-through or fault result is valid on the cycle after acceptance. `req_ready` stays low from acceptance until the response is taken.
- R10: `rsp_valid` and the response fields hold steady until `rsp_ready`. `wk_valid` and the walk fields hold steady until `wk_ready`. Each drops in the cycle after its handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| atp_ctrl | input | 64 | Translation control: scheme [63:60], ASID [59:44], root page number [43:0] |
| st_mxr | input | 1 | Make-executable-readable flag |
| st_sum | input | 1 | Supervisor-may-access-user flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 atomic |
| req_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| wk_valid | output | 1 | Walk request valid |
| wk_ready | input | 1 | Walker accepts request |
| wk_vaddr | output | 48 | Truncated virtual address |
| wk_asid | output | 16 | Address-space identifier |
| wk_root | output | 44 | Root page-table page number |
| wk_level | output | 2 | Starting level |
| wk_mxr | output | 1 | MXR flag for the walk |
| wk_sum | output | 1 | SUM flag for the walk |
| wr_valid | input | 1 | Walker response valid |
| wr_fault | input | 1 | Walk ended in a page fault |
| wr_paddr | input | 56 | Physical address from the walker |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_cause | output | 6 | Exception cause when faulting, else 0 |
| rsp_paddr | output | 64 | Physical address when not faulting, else 0 |

## Verification
A pass-through or invalid-address result is due one clock edge after the accepting edge. The same edge raises the walk request on the walk path. A walker answer shows on the response port one edge after the edge that sampled `wr_valid`. The bench drives every input on the falling edge and samples the outputs on the next falling edge after each such rising edge, so each result is checked in exactly the cycle it is due. While a ready is held low for a random number of cycles, it re-samples on every falling edge to confirm that the outputs hold.

// File: rtl/xlt_pkg.sv
// Package: shared encodings for the translation front-end.
// Assumes the standard page-fault cause numbers and a 2-bit access kind.
package xlt_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_AMO   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        SCH_BARE = 2'd0,
        SCH_L3   = 2'd1,
        SCH_L4   = 2'd2
    } scheme_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } state_e;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;
    localparam int         CAUSE_W      = 6;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_PF = 6'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PF  = 6'd13;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_PF = 6'd15;

    // Map an access kind to its page-fault cause code.
    function automatic logic [CAUSE_W-1:0] page_fault_cause(input logic [1:0] acc);
        case (acc)
            2'd0:    return CAUSE_FETCH_PF;
            2'd1:    return CAUSE_LOAD_PF;
            default: return CAUSE_STORE_PF;
        endcase
    endfunction

endpackage

// File: rtl/xlt_scheme_sel.sv
// Scheme selector: turns privilege and the control-word scheme field into
// one of pass-through, three-level or four-level translation.
// Assumes unknown scheme codes are treated as pass-through.
module xlt_scheme_sel #(
    parameter int          MODE_W  = 4,
    parameter logic [3:0]  CODE_L3 = 4'd8,
    parameter logic [3:0]  CODE_L4 = 4'd9
) (
    input  logic [1:0]        priv,
    input  logic [MODE_W-1:0] mode,
    output xlt_pkg::scheme_e  scheme
);
    import xlt_pkg::*;

    // Machine privilege forces pass-through; otherwise decode the field.
    always_comb begin
        if (priv == PRIV_MACHINE)              scheme = SCH_BARE;
        else if (mode == MODE_W'(CODE_L3))     scheme = SCH_L3;
        else if (mode == MODE_W'(CODE_L4))     scheme = SCH_L4;
        else                                   scheme = SCH_BARE;
    end
endmodule

// File: rtl/xlt_sign_chk.sv
// Sign-run checker: reports whether every bit of a slice is equal,
// i.e. the upper address bits are a pure sign extension.
module xlt_sign_chk #(
    parameter int W = 26
) (
    input  logic [W-1:0] bits_in,
    output logic         uniform
);
    // All zeros or all ones counts as a valid sign run.
    always_comb uniform = (bits_in == '0) || (bits_in == '1);
endmodule

// File: rtl/xlt_canon_chk.sv
// Canonical-address checker for the selected scheme. Takes only the address
// bits from the 39-bit sign position upward. Pass-through is always canonical.
module xlt_canon_chk #(
    parameter int XLEN  = 64,
    parameter int L3_VA = 39,
    parameter int L4_VA = 48
) (
    input  logic [XLEN-L3_VA:0] hi,
    input  xlt_pkg::scheme_e    scheme,
    output logic                ok
);
    import xlt_pkg::*;

    localparam int HI_W  = XLEN - L3_VA + 1;
    localparam int L4_LO = L4_VA - L3_VA;
    localparam int L4_W  = HI_W - L4_LO;

    logic ok_l3, ok_l4;

    xlt_sign_chk #(.W(HI_W)) u_l3 (.bits_in(hi), .uniform(ok_l3));
    xlt_sign_chk #(.W(L4_W)) u_l4 (.bits_in(hi[HI_W-1:L4_LO]), .uniform(ok_l4));

    // Pick the sign-run result that belongs to the active scheme.
    always_comb begin
        case (scheme)
            SCH_L3:  ok = ok_l3;
            SCH_L4:  ok = ok_l4;
            default: ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/xlate_front.sv
// Translation front-end. Accepts one request at a time. It either returns a
// pass-through or invalid-address result on the next cycle, or issues a walk
// request and relays the walker's answer. Assumes the walker answers only
// requests it has accepted; wr_valid outside the wait state is ignored.
module xlate_front #(
    parameter int XLEN   = 64,
    parameter int MODE_W = 4,
    parameter int ASID_W = 16,
    parameter int ROOT_W = 44,
    parameter int PA_W   = 56,
    parameter int L3_VA  = 39,
    parameter int L4_VA  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   atp_ctrl,
    input  logic              st_mxr,
    input  logic              st_sum,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [XLEN-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_priv,
    output logic              wk_valid,
    input  logic              wk_ready,
    output logic [L4_VA-1:0]  wk_vaddr,
    output logic [ASID_W-1:0] wk_asid,
    output logic [ROOT_W-1:0] wk_root,
    output logic [1:0]        wk_level,
    output logic              wk_mxr,
    output logic              wk_sum,
    input  logic              wr_valid,
    input  logic              wr_fault,
    input  logic [PA_W-1:0]   wr_paddr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [5:0]        rsp_cause,
    output logic [XLEN-1:0]   rsp_paddr
);
    import xlt_pkg::*;

    localparam int MODE_LSB = XLEN - MODE_W;
    localparam int ASID_LSB = MODE_LSB - ASID_W;
    localparam logic [1:0] LEVEL_L3 = 2'd2;
    localparam logic [1:0] LEVEL_L4 = 2'd3;

    state_e            st;
    scheme_e           scheme;
    logic              canon_ok;
    logic [1:0]        acc_q;
    logic [L4_VA-1:0]  l3_addr;

    xlt_scheme_sel #(.MODE_W(MODE_W)) u_sel (
        .priv   (req_priv),
        .mode   (atp_ctrl[XLEN-1:MODE_LSB]),
        .scheme (scheme)
    );

    xlt_canon_chk #(.XLEN(XLEN), .L3_VA(L3_VA), .L4_VA(L4_VA)) u_canon (
        .hi     (req_vaddr[XLEN-1:L3_VA-1]),
        .scheme (scheme),
        .ok     (canon_ok)
    );

    // Truncated address for the three-level scheme, zero-filled to port width.
    always_comb l3_addr = {{(L4_VA-L3_VA){1'b0}}, req_vaddr[L3_VA-1:0]};

    // Handshake flags follow the state directly.
    always_comb begin
        req_ready = (st == ST_IDLE);
        wk_valid  = (st == ST_ISSUE);
        rsp_valid = (st == ST_RESP);
    end

    // Request sequencing: classify, issue a walk, collect it, hand back the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            acc_q     <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
            wk_vaddr  <= '0;
            wk_asid   <= '0;
            wk_root   <= '0;
            wk_level  <= '0;
            wk_mxr    <= 1'b0;
            wk_sum    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    acc_q <= req_acc;
                    if (scheme == SCH_BARE) begin
                        rsp_paddr <= req_vaddr;
                        rsp_fault <= 1'b0;
                        rsp_cause <= '0;
                        st        <= ST_RESP;
                    end else if (!canon_ok) begin
                        rsp_paddr <= '0;
                        rsp_fault <= 1'b1;
                        rsp_cause <= page_fault_cause(req_acc);
                        st        <= ST_RESP;
                    end else begin
                        wk_vaddr <= (scheme == SCH_L3) ? l3_addr : req_vaddr[L4_VA-1:0];
                        wk_level <= (scheme == SCH_L3) ? LEVEL_L3 : LEVEL_L4;
                        wk_asid  <= atp_ctrl[MODE_LSB-1:ASID_LSB];
                        wk_root  <= atp_ctrl[ROOT_W-1:0];
                        wk_mxr   <= st_mxr;
                        wk_sum   <= st_sum;
                        st       <= ST_ISSUE;
                    end
                end
                ST_ISSUE: if (wk_ready) st <= ST_WAIT;
                ST_WAIT: if (wr_valid) begin
                    rsp_fault <= wr_fault;
                    rsp_cause <= wr_fault ? page_fault_cause(acc_q) : '0;
                    rsp_paddr <= wr_fault ? '0 : {{(XLEN-PA_W){1'b0}}, wr_paddr};
                    st        <= ST_RESP;
                end
                default: if (rsp_ready) st <= ST_IDLE;
            endcase
        end
    end

    // R1: machine privilege yields a clean pass-through on the next cycle.
    a_r1_machine_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_priv == PRIV_MACHINE) |=>
        (rsp_valid && !rsp_fault && !wk_valid && rsp_paddr == $past(req_vaddr)));

    // R5: a fault response always carries one of the three page-fault causes.
    a_r5_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |->
        (rsp_cause == CAUSE_FETCH_PF || rsp_cause == CAUSE_LOAD_PF ||
         rsp_cause == CAUSE_STORE_PF) && rsp_paddr == '0);

    // R6: a walk always starts from level 2 or 3.
    a_r6_level: assert property (@(posedge clk) disable iff (!rst_n)
        wk_valid |-> (wk_level == LEVEL_L3 || wk_level == LEVEL_L4));

    // R8: a good walk answer returns with its upper bits cleared.
    a_r8_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_valid == 1'b0 && !rsp_valid && !req_ready && wr_valid && !wr_fault) |=>
        (rsp_valid && !rsp_fault && rsp_paddr[XLEN-1:PA_W] == '0));

    // R9: no new request is taken while a response is pending.
    a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || wk_valid) |-> !req_ready);

    // R10: the response holds until it is taken.
    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_cause)));

    // R10: the walk request holds until the walker takes it.
    a_r10_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_valid && !wk_ready) |=>
        (wk_valid && $stable(wk_vaddr) && $stable(wk_level) && $stable(wk_root)));
endmodule

// File: tb/xlate_front_tb.sv
module xlate_front_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] atp_ctrl;
    logic        st_mxr, st_sum;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_vaddr;
    logic [1:0]  req_acc, req_priv;
    logic        wk_valid, wk_ready;
    logic [47:0] wk_vaddr;
    logic [15:0] wk_asid;
    logic [43:0] wk_root;
    logic [1:0]  wk_level;
    logic        wk_mxr, wk_sum;
    logic        wr_valid, wr_fault;
    logic [55:0] wr_paddr;
    logic        rsp_valid, rsp_ready, rsp_fault;
    logic [5:0]  rsp_cause;
    logic [63:0] rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    xlate_front u_dut (.*);

    // Watchdog: an overrun counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit good, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!good) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected scheme: 0 pass-through, 1 three-level, 2 four-level (R1, R2).
    function automatic int exp_scheme(input logic [1:0] pv, input logic [63:0] c);
        if (pv == 2'b11) return 0;
        if (c[63:60] == 4'd8) return 1;
        if (c[63:60] == 4'd9) return 2;
        return 0;
    endfunction

    // Expected canonical result (R3, R4).
    function automatic bit exp_canon(input int s, input logic [63:0] va);
        if (s == 1) return (va[63:39] == {25{va[38]}});
        if (s == 2) return (va[63:48] == {16{va[47]}});
        return 1'b1;
    endfunction

    function automatic logic [5:0] exp_cause(input logic [1:0] a);
        return (a == 2'd0) ? 6'd12 : (a == 2'd1) ? 6'd13 : 6'd15;
    endfunction

    // One full transaction with its checks.
    task automatic send(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] pv,
                        input logic [63:0] ctrl, input bit mxr, input bit sum,
                        input bit wf, input logic [55:0] pa,
                        input int kdly, input int wdly, input int rdly);
        int s;
        bit ok;
        logic [63:0] e_pa;
        logic [5:0]  e_cause;
        bit          e_fault;
        logic [47:0] e_wva;
        s  = exp_scheme(pv, ctrl);
        ok = exp_canon(s, va);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
        atp_ctrl = ctrl; st_mxr = mxr; st_sum = sum;
        req_vaddr = va; req_acc = acc; req_priv = pv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = {$urandom, $urandom};
        chk(req_ready == 1'b0, "R9", "ready low while busy", 64'(req_ready), 64'd0);
        if (s == 0 || !ok) begin
            chk(rsp_valid == 1'b1, "R9", "result one cycle after accept", 64'(rsp_valid), 64'd1);
            chk(wk_valid == 1'b0, (s == 0) ? "R1" : "R5", "no walk", 64'(wk_valid), 64'd0);
            if (s == 0) begin
                e_fault = 1'b0; e_cause = 6'd0; e_pa = va;
                chk(rsp_paddr == va, (pv == 2'b11) ? "R1" : "R2", "pass-through addr", rsp_paddr, va);
            end else begin
                e_fault = 1'b1; e_cause = exp_cause(acc); e_pa = 64'd0;
                chk(rsp_cause == e_cause, (s == 1) ? "R3" : "R4", "non-canonical cause",
                    64'(rsp_cause), 64'(e_cause));
            end
            chk(rsp_fault == e_fault, "R5", "fault flag", 64'(rsp_fault), 64'(e_fault));
        end else begin
            e_wva = (s == 1) ? {9'd0, va[38:0]} : va[47:0];
            chk(wk_valid == 1'b1, "R6", "walk issued", 64'(wk_valid), 64'd1);
            chk(rsp_valid == 1'b0, "R6", "no early result", 64'(rsp_valid), 64'd0);
            chk(wk_vaddr == e_wva, "R6", "walk addr", 64'(wk_vaddr), 64'(e_wva));
            chk(wk_level == ((s == 1) ? 2'd2 : 2'd3), "R6", "walk level",
                64'(wk_level), (s == 1) ? 64'd2 : 64'd3);
            chk(wk_asid == ctrl[59:44] && wk_root == ctrl[43:0], "R7", "asid/root",
                {4'd0, wk_asid, wk_root}, {4'd0, ctrl[59:0]});
            chk(wk_mxr == mxr && wk_sum == sum, "R7", "mxr/sum",
                64'({wk_mxr, wk_sum}), 64'({mxr, sum}));
            for (int k = 0; k < kdly; k++) begin
                @(negedge clk);
                chk(wk_valid == 1'b1 && wk_vaddr == e_wva, "R10", "walk held",
                    64'(wk_vaddr), 64'(e_wva));
            end
            wk_ready = 1'b1;
            @(negedge clk);
            wk_ready = 1'b0;
            chk(wk_valid == 1'b0, "R10", "walk drops after handshake", 64'(wk_valid), 64'd0);
            repeat (wdly) @(negedge clk);
            wr_valid = 1'b1; wr_fault = wf; wr_paddr = pa;
            @(negedge clk);
            wr_valid = 1'b0; wr_paddr = {$urandom, $urandom}; wr_fault = $urandom;
            e_fault = wf;
            e_cause = wf ? exp_cause(acc) : 6'd0;
            e_pa    = wf ? 64'd0 : {8'd0, pa};
            chk(rsp_valid == 1'b1, "R8", "walk result valid", 64'(rsp_valid), 64'd1);
            chk(rsp_paddr == e_pa, "R8", "walk result addr", rsp_paddr, e_pa);
            chk(rsp_fault == e_fault && rsp_cause == e_cause, "R8", "walk result cause",
                64'({rsp_fault, rsp_cause}), 64'({e_fault, e_cause}));
        end
        for (int k = 0; k < rdly; k++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b1 && rsp_paddr == e_pa && rsp_cause == e_cause, "R10",
                "response held", rsp_paddr, e_pa);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid == 1'b0, "R10", "response drops after handshake", 64'(rsp_valid), 64'd0);
    endtask

    function automatic logic [63:0] pick_ctrl(input int m);
        logic [63:0] c;
        c = {$urandom, $urandom};
        case (m % 5)
            0: c[63:60] = 4'd0;
            1: c[63:60] = 4'd8;
            2: c[63:60] = 4'd9;
            3: c[63:60] = 4'd5;
            default: c[63:60] = 4'd15;
        endcase
        return c;
    endfunction

    function automatic logic [63:0] pick_va(input int m);
        logic [63:0] x;
        x = {$urandom, $urandom};
        case (m % 4)
            0: return x;
            1: return {{25{x[38]}}, x[38:0]};
            2: return {{16{x[47]}}, x[47:0]};
            default: begin
                x = {{25{x[38]}}, x[38:0]};
                x[39 + ($urandom % 25)] ^= 1'b1;
                return x;
            end
        endcase
    endfunction

    localparam logic [63:0] C_L3 = {4'd8, 16'hA5C3, 44'h123_4567_89AB};
    localparam logic [63:0] C_L4 = {4'd9, 16'h0F0F, 44'hFED_CBA9_8765};

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; atp_ctrl = '0; st_mxr = 1'b0; st_sum = 1'b0;
        req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_priv = '0;
        wk_ready = 1'b0; wr_valid = 1'b0; wr_fault = 1'b0; wr_paddr = '0; rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && wk_valid == 1'b0, "R9", "reset state",
            64'({req_ready, rsp_valid, wk_valid}), 64'b100);

        // R3: bit 38 set with upper ones is canonical; with upper zeros it faults.
        send(64'hFFFF_FFC0_0000_1000, 2'd1, 2'd1, C_L3, 1'b1, 1'b0, 1'b0, 56'hAB_CDEF_0123_4567, 1, 2, 0);
        send(64'h0000_0040_0000_1000, 2'd1, 2'd1, C_L3, 1'b0, 1'b1, 1'b0, 56'h0, 0, 0, 0);
        send(64'h0000_003F_FFFF_F000, 2'd0, 2'd0, C_L3, 1'b0, 1'b0, 1'b0, 56'hFF_FFFF_FFFF_FFFF, 0, 0, 1);
        send(64'h8000_0000_0000_0000, 2'd0, 2'd1, C_L3, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        // R4: bit 47 edge cases.
        send(64'hFFFF_8000_0000_0040, 2'd2, 2'd1, C_L4, 1'b1, 1'b1, 1'b0, 56'h12_3456_789A_BCDE, 2, 1, 2);
        send(64'h0000_8000_0000_0040, 2'd2, 2'd1, C_L4, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        send(64'h0000_7FFF_FFFF_FFF8, 2'd3, 2'd0, C_L4, 1'b0, 1'b0, 1'b0, 56'h00_0000_0000_1000, 0, 3, 0);
        // R5: each access kind gets its own cause.
        send(64'h0100_0000_0000_0000, 2'd0, 2'd1, C_L4, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        send(64'h0100_0000_0000_0000, 2'd1, 2'd1, C_L4, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        send(64'h0100_0000_0000_0000, 2'd2, 2'd1, C_L4, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        send(64'h0100_0000_0000_0000, 2'd3, 2'd1, C_L4, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        // R1: machine mode ignores the scheme and the canonical rule.
        send(64'h0123_4567_89AB_CDEF, 2'd1, 2'd3, C_L3, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 1);
        send(64'h0123_4567_89AB_CDEF, 2'd2, 2'd3, C_L4, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        // R2: scheme 0 and unknown codes pass through.
        send(64'h0123_4567_89AB_CDEF, 2'd1, 2'd1, {4'd0, 60'h1}, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        send(64'h0123_4567_89AB_CDEF, 2'd1, 2'd0, {4'd10, 60'h1}, 1'b0, 1'b0, 1'b0, 56'h0, 0, 0, 0);
        // R8: failed walks map to the access kind.
        send(64'h0000_0000_0000_2000, 2'd0, 2'd1, C_L3, 1'b0, 1'b0, 1'b1, 56'h55, 0, 1, 0);
        send(64'h0000_0000_0000_2000, 2'd3, 2'd1, C_L4, 1'b0, 1'b0, 1'b1, 56'h55, 1, 0, 1);

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic [1:0] pv;
            pv = ($urandom % 5 == 0) ? 2'd3 : 2'($urandom % 2);
            send(pick_va($urandom), 2'($urandom), pv, pick_ctrl($urandom),
                 1'($urandom), 1'($urandom), ($urandom % 4 == 0),
                 {$urandom, $urandom}, $urandom % 3, $urandom % 4, $urandom % 3);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule